// File: doc/BRIEF.md
# Posted Write-Through Store Buffer

This block holds one pending 64-bit store that has to reach external memory at once. That covers stores to write-through regions and stores to uncached regions. The CPU presents a store with a 29-bit physical byte address, a size code and right-aligned data. When the slot is empty the store is taken in one cycle and the CPU moves on. The buffer then raises a write request toward memory and holds it until memory acknowledges.

Byte enables come from the size code and the low three address bits. The data is moved into its byte lanes inside the 64-bit slot. A load to the same doubleword as the pending store is told to stall, so that it cannot read stale memory. A store whose size does not match its address alignment is reported on an error output and is dropped.

Top module: `wtbuf_top`

## Requirements
- R1: After reset, `stReady` is 1 and `memReq` is 0.
- R2: When the buffer is empty, an aligned store with `stValid`=1 is taken at the clock edge. From the next cycle `memReq` is 1 and `memAddr` equals the full store address.
- R3: `memBe` covers 2^`stSize` bytes, starting at byte lane `stAddr[2:0]`. The size code is 0 for byte, 1 for 2-byte, 2 for 4-byte and 3 for 8-byte. `memBe[i]` maps to `memData[8i+7:8i]`.
- R4: `memData` holds the low 2^`stSize` bytes of `stData`, moved up to the enabled lanes. Every byte outside the enabled lanes reads zero.
- R5: While `memReq`=1 and `memAck`=0, `memReq`, `memAddr`, `memData` and `memBe` stay unchanged on the next cycle.
- R6: While a write is pending, `stReady` is 0 and no new store is taken. `stReady` returns to 1 in the cycle after the one in which `memAck` is seen. A store that is held on `stValid` is then taken at the following edge.
- R7: A store is misaligned when `stAddr` is not a multiple of 2^`stSize`. For such a store `stError` is 1 in the same cycle, and the store is not buffered: `memReq` stays 0.
- R8: `ldStall` is 1 when `ldValid`=1, a write is pending, and `ldAddr[28:3]` equals the pending address bits [28:3].
- R9: `ldStall` is 0 for a load to a different doubleword, and it is 0 once the pending write has been acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stValid | input | 1 | Store request from the CPU |
| stAddr | input | 29 | Physical byte address of the store |
| stSize | input | 2 | Size code: 0 byte, 1 two bytes, 2 four bytes, 3 eight bytes |
| stData | input | 64 | Store data, right-aligned |
| stReady | output | 1 | Buffer can take a store this cycle |
| stError | output | 1 | Presented store is misaligned and is dropped |
| ldValid | input | 1 | A load is being issued |
| ldAddr | input | 29 | Physical address of that load |
| ldStall | output | 1 | Load must wait for the pending write |
| memReq | output | 1 | Write request to memory |
| memAddr | output | 29 | Full byte address of the pending write |
| memData | output | 64 | Lane-placed write data |
| memBe | output | 8 | Byte enables of the pending write |
| memAck | input | 1 | Memory has taken the write |

## Verification
The assertions check on every cycle that a request holds steady until it is acknowledged. They also check that a pending write stays pending without an acknowledge, that an aligned store into an empty slot produces a request, that a misaligned store never produces one, that the enable count is a power of two, and that a stall only occurs while a write is pending. The exact lane placement, the masking of bytes outside the store, and the enable pattern for each size and offset can only be shown by the bench's vectors. The same holds for the cycle in which a held store is finally taken after an acknowledge, and for the doubleword match on loads.

// File: rtl/wtbuf_pkg.sv
package wtbuf_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } sizeE;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;  // load the slot with the presented store
    logic drain;    // memory took the pending write this cycle
  } ctlT;
endpackage

// File: rtl/wtbuf_ctrl.sv
module wtbuf_ctrl
  import wtbuf_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic stValid,
  input  logic misaligned,
  input  logic memAck,
  output logic stReady,
  output logic pending,
  output ctlT  ctl
);
  logic fullQ;

  always_ff @(posedge clk) begin
    if (!rstN)             fullQ <= 1'b0;
    else if (ctl.capture)  fullQ <= 1'b1;
    else if (ctl.drain)    fullQ <= 1'b0;
  end

  always_comb begin
    ctl.capture = stValid && !fullQ && !misaligned;
    ctl.drain   = fullQ && memAck;
    stReady     = !fullQ;
    pending     = fullQ;
  end

  // R6: a pending write is kept until memory acknowledges it
  a_r6_hold_pending: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !memAck) |=> pending);
endmodule

// File: rtl/wtbuf_datapath.sv
module wtbuf_datapath
  import wtbuf_pkg::*;
#(
  parameter int ADDR_W = 29,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlT               ctl,
  input  logic              pending,
  input  logic [ADDR_W-1:0] stAddr,
  input  logic [1:0]        stSize,
  input  logic [DATA_W-1:0] stData,
  input  logic              ldValid,
  input  logic [ADDR_W-1:0] ldAddr,
  output logic              misaligned,
  output logic              ldStall,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic [DATA_W/8-1:0] memBe
);
  localparam int BYTES = DATA_W / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [OFF_W-1:0]  offset;
  logic [BYTES-1:0]  widthMask;
  logic [BYTES-1:0]  beNext;
  logic [DATA_W-1:0] laneMask;
  logic [DATA_W-1:0] shifted;
  logic [OFF_W-1:0]  alignMask;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [BYTES-1:0]  beQ;

  assign offset = stAddr[OFF_W-1:0];

  always_comb begin
    for (int i = 0; i < BYTES; i++)
      widthMask[i] = (i < (1 << stSize));
    alignMask  = OFF_W'((1 << stSize) - 1);
    misaligned = (offset & alignMask) != '0;
    beNext     = widthMask << offset;
    shifted    = stData << {offset, 3'b000};
  end

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign laneMask[8*b +: 8] = {8{beNext[b]}};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
      beQ   <= '0;
    end else if (ctl.capture) begin
      addrQ <= stAddr;
      dataQ <= shifted & laneMask;
      beQ   <= beNext;
    end
  end

  assign ldStall = ldValid && pending &&
                   (ldAddr[ADDR_W-1:OFF_W] == addrQ[ADDR_W-1:OFF_W]);
  assign memAddr = addrQ;
  assign memData = dataQ;
  assign memBe   = beQ;
endmodule

// File: rtl/wtbuf_top.sv
module wtbuf_top
  import wtbuf_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        stValid,
  input  logic [28:0] stAddr,
  input  logic [1:0]  stSize,
  input  logic [63:0] stData,
  output logic        stReady,
  output logic        stError,
  input  logic        ldValid,
  input  logic [28:0] ldAddr,
  output logic        ldStall,
  output logic        memReq,
  output logic [28:0] memAddr,
  output logic [63:0] memData,
  output logic [7:0]  memBe,
  input  logic        memAck
);
  ctlT  ctl;
  logic misaligned;
  logic pending;

  wtbuf_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .misaligned(misaligned),
    .memAck(memAck), .stReady(stReady), .pending(pending), .ctl(ctl)
  );

  wtbuf_datapath #(.ADDR_W(29), .DATA_W(64)) i_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .pending(pending),
    .stAddr(stAddr), .stSize(stSize), .stData(stData),
    .ldValid(ldValid), .ldAddr(ldAddr), .misaligned(misaligned),
    .ldStall(ldStall), .memAddr(memAddr), .memData(memData), .memBe(memBe)
  );

  assign memReq  = pending;
  assign stError = stValid && misaligned;

  // R2: aligned store into empty slot leads to a request
  a_r2_accept_req: assert property (@(posedge clk) disable iff (!rstN)
    (stValid && stReady && !stError) |=> memReq);
  // R5: request fields hold until acknowledged
  a_r5_req_stable: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memData) && $stable(memBe)));
  // R7: a misaligned store into an empty slot leaves it empty
  a_r7_err_dropped: assert property (@(posedge clk) disable iff (!rstN)
    (!memReq && stError) |=> !memReq);
  // R3: enable count is a power of two while requesting
  a_r3_be_count: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> ($countones(memBe) inside {1, 2, 4, 8}));
  // R8: a stall only happens with a pending write
  a_r8_stall_pending: assert property (@(posedge clk) disable iff (!rstN)
    ldStall |-> memReq);
endmodule

// File: tb/test_wtbuf_top.sv
module test_wtbuf_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NVEC = 6;

  typedef struct packed {
    logic [28:0] addr;
    logic [1:0]  size;
    logic [63:0] data;
    logic [7:0]  expBe;
    logic [63:0] expData;
  } vecT;

  localparam vecT VECS [NVEC] = '{
    '{29'h0000_0003, 2'd0, 64'h0000_0000_0000_00AB, 8'h08, 64'h0000_0000_AB00_0000},
    '{29'h0001_0006, 2'd1, 64'h0000_0000_0000_1234, 8'hC0, 64'h1234_0000_0000_0000},
    '{29'h1000_0004, 2'd2, 64'h0000_0000_DEAD_BEEF, 8'hF0, 64'hDEAD_BEEF_0000_0000},
    '{29'h0ABC_DEF8, 2'd3, 64'h0123_4567_89AB_CDEF, 8'hFF, 64'h0123_4567_89AB_CDEF},
    '{29'h0000_0010, 2'd0, 64'hFFFF_FFFF_FFFF_FF5A, 8'h01, 64'h0000_0000_0000_005A},
    '{29'h1FFF_FFFA, 2'd1, 64'hFFFF_0000_0000_BEEF, 8'h0C, 64'h0000_0000_BEEF_0000}
  };

  logic clk = 0, rstN = 0;
  logic stValid = 0, ldValid = 0, memAck = 0;
  logic [28:0] stAddr = '0, ldAddr = '0;
  logic [1:0]  stSize = '0;
  logic [63:0] stData = '0;
  logic stReady, stError, ldStall, memReq;
  logic [28:0] memAddr;
  logic [63:0] memData;
  logic [7:0]  memBe;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wtbuf_top i_wtbuf_top (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stSize(stSize),
    .stData(stData), .stReady(stReady), .stError(stError), .ldValid(ldValid),
    .ldAddr(ldAddr), .ldStall(ldStall), .memReq(memReq), .memAddr(memAddr),
    .memData(memData), .memBe(memBe), .memAck(memAck)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ack();
    @(negedge clk) memAck = 1;
    @(negedge clk) memAck = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 stReady", stReady, 1);
    chk("R1 memReq", memReq, 0);
    rstN = 1;

    for (int v = 0; v < NVEC; v++) begin
      @(negedge clk);
      stValid = 1; stAddr = VECS[v].addr; stSize = VECS[v].size; stData = VECS[v].data;
      @(negedge clk);
      stValid = 0;
      chk("R2 memReq", memReq, 1);
      chk("R2 memAddr", memAddr, VECS[v].addr);
      chk("R3 memBe", memBe, VECS[v].expBe);
      chk("R4 memData", memData, VECS[v].expData);
      chk("R6 stReady low", stReady, 0);
      ldValid = 1; ldAddr = {VECS[v].addr[28:3], 3'b111};
      #1 chk("R8 ldStall same dword", ldStall, 1);
      ldAddr = VECS[v].addr ^ 29'h8;
      #1 chk("R9 ldStall other dword", ldStall, 0);
      @(negedge clk);
      chk("R5 memReq held", memReq, 1);
      chk("R5 memAddr held", memAddr, VECS[v].addr);
      memAck = 1;
      @(negedge clk);
      memAck = 0;
      chk("R6 stReady back", stReady, 1);
      ldAddr = VECS[v].addr;
      #1 chk("R9 ldStall after ack", ldStall, 0);
      ldValid = 0;
    end

    // R7: misaligned 4-byte store at offset 2
    @(negedge clk);
    stValid = 1; stAddr = 29'h0000_0102; stSize = 2'd2; stData = 64'h1;
    #1 chk("R7 stError", stError, 1);
    @(negedge clk);
    stValid = 0;
    chk("R7 not buffered", memReq, 0);
    // R7: misaligned 8-byte store
    stValid = 1; stAddr = 29'h0000_0204; stSize = 2'd3;
    #1 chk("R7 stError dbl", stError, 1);
    @(negedge clk);
    stValid = 0;
    chk("R7 dbl not buffered", memReq, 0);

    // R6: second store held while first pending
    stValid = 1; stAddr = 29'h0000_0040; stSize = 2'd3; stData = 64'h1111;
    @(negedge clk);
    stAddr = 29'h0000_0080; stData = 64'h2222;
    chk("R6 first taken", memAddr, 29'h0000_0040);
    chk("R6 ready low", stReady, 0);
    @(negedge clk);
    chk("R6 second not taken", memAddr, 29'h0000_0040);
    chk("R6 data kept", memData, 64'h1111);
    memAck = 1;
    @(negedge clk);
    memAck = 0;
    chk("R6 slot free after ack", memReq, 0);
    chk("R6 ready after ack", stReady, 1);
    @(negedge clk);
    stValid = 0;
    chk("R6 held store taken", memAddr, 29'h0000_0080);
    chk("R6 held store req", memReq, 1);
    ack();
    chk("R9 drained", memReq, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule